// File: doc/BRIEF.md
# Dual-Loop Mode Decoder with 8 kHz Divide Path

This block turns a four-bit select word into the operating controls of two timing loops that share the word. The first loop makes a 1.544 MHz line clock. The second loop makes 4.096 MHz and 2.048 MHz clocks and an 8 kHz frame pulse. The block sets each loop's major mode. For the second loop it also picks the 8 kHz reference source and the reference edge it locks to, and whether an external 4.096 MHz clock replaces its own clock. It also sets the direction of each shared pin. The loop cores are not part of this block.

In the divide modes the block counts cycles of an external 1.544 MHz or 2.048 MHz clock, which is also the block's own clock `clk`. From this count it forms an internal 8 kHz signal. That signal replaces the 8 kHz pin as the second loop's reference and is driven out on that pin. The second loop then locks to the falling edge of this signal instead of the rising edge. The select word is sampled only while reset is held low, so the mode stays fixed for the whole time the block runs.

Top module: `trunk_mode_div`

## Requirements
- R1: `mode_sel_i` is captured on every clock edge while `rst_n` is low. While `rst_n` is high, changes on `mode_sel_i` do not affect any output.
- R2: Bit numbering: `mode_sel_i[0]` is the divide-ratio/major bit A, `[1]` is the divide bit D, `[2]` is the frame-direction bit, and `[3]` is the clock-override bit (active low). When D=0: `t1_track_o`=1, `t1_div_o`=0, `tick8k_o`=0, and bit A has no effect on the first loop.
- R3: When D=1, `t1_div_o`=1 and `t1_div256_o`=A. `tick8k_o` repeats with a period of 193 clocks (A=0) or 256 clocks (A=1). It is high for clocks 0..127 of each period, counting from clock 0 = the first cycle after reset release. This gives about 66% duty at 193 and 50% at 256.
- R4: `p2_major_o` = {D, A}. The codes are 0 = normal, 1 = free-run, 2 = single-clock at 193, and 3 = single-clock at 256.
- R5: `p2_ref_o` selects the second loop's reference: 0 = 8 kHz pin when D=0 and A=0, 1 = frame pin (16 kHz, free-run) when D=0 and A=1, 2 = internal divided signal when D=1. `p2_fall_o`=1 (falling-edge lock) exactly when D=1.
- R6: `c8k_oe_o`=1 (the 8 kHz pin drives `tick8k_o` out) exactly when D=1.
- R7: `p2_ext4m_o` = NOT bit 3 (an external 4.096 MHz clock overrides the major mode). `c4_oe_o` = bit 3.
- R8: `frame_oe_o` = bit 2 (frame pin is an output when 1).
- R9: `var_oe_o` = `var_en_i` AND NOT D. `var_inv_oe_o` = `var_en_i` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External 1.544/2.048 MHz clock, also the block clock |
| rst_n | input | 1 | Active-low reset; the select word is sampled while it is low |
| mode_sel_i | input | 4 | Select word {override_n, frame_dir, D, A} |
| var_en_i | input | 1 | Enable for the variable-clock outputs |
| t1_track_o | output | 1 | First loop in line-clock tracking mode |
| t1_div_o | output | 1 | First loop in divide mode |
| t1_div256_o | output | 1 | Divide ratio is 256 (else 193) |
| p2_major_o | output | 2 | Second-loop major mode code |
| p2_ext4m_o | output | 1 | Second loop uses the external 4.096 MHz clock |
| p2_ref_o | output | 2 | Second-loop reference source |
| p2_fall_o | output | 1 | Second loop locks to the falling edge |
| c8k_oe_o | output | 1 | Output enable of the 8 kHz pin |
| frame_oe_o | output | 1 | Output enable of the frame pin |
| c4_oe_o | output | 1 | Output enable of the 4.096 MHz pin |
| var_oe_o | output | 1 | Output enable of the variable-clock pin |
| var_inv_oe_o | output | 1 | Output enable of the inverted variable-clock pin |
| tick8k_o | output | 1 | Divided 8 kHz signal |

## Verification
The assertions assume that reset is held low for at least one clock edge before it is released. This way the captured select word is valid before any property is armed, and the divide counter starts from zero. The stimulus applies every select word, with the enable both high and low. Each run starts with a two-clock reset that carries the word. Only after release does the stimulus change the select word, which tests that it is ignored. Inputs change on falling clock edges, so no property ever sees a select change at its own sampling edge.

// File: rtl/trunk_mode_div.sv
module trunk_mode_div #(
  parameter int RATIO_LO = 193,
  parameter int RATIO_HI = 256,
  parameter int HIGH_CYC = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_sel_i,
  input  logic       var_en_i,
  output logic       t1_track_o,
  output logic       t1_div_o,
  output logic       t1_div256_o,
  output logic [1:0] p2_major_o,
  output logic       p2_ext4m_o,
  output logic [1:0] p2_ref_o,
  output logic       p2_fall_o,
  output logic       c8k_oe_o,
  output logic       frame_oe_o,
  output logic       c4_oe_o,
  output logic       var_oe_o,
  output logic       var_inv_oe_o,
  output logic       tick8k_o
);
  localparam int CW = $clog2(RATIO_HI + 1);
  localparam logic [CW-1:0] LAST_LO = CW'(RATIO_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(RATIO_HI - 1);
  localparam logic [CW-1:0] HI_LIM  = CW'(HIGH_CYC);

  logic [3:0]    sel_q;
  logic [CW-1:0] cnt;
  logic          div_on, wide;
  logic [CW-1:0] last;

  always_ff @(posedge clk)
    if (!rst_n) sel_q <= mode_sel_i;

  assign div_on = sel_q[1];
  assign wide   = sel_q[0];
  assign last   = wide ? LAST_HI : LAST_LO;

  always_ff @(posedge clk)
    if (!rst_n || !div_on) cnt <= '0;
    else if (cnt == last)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;

  assign tick8k_o     = div_on && (cnt < HI_LIM);
  assign t1_track_o   = ~div_on;
  assign t1_div_o     = div_on;
  assign t1_div256_o  = div_on & wide;
  assign p2_major_o   = sel_q[1:0];
  assign p2_ext4m_o   = ~sel_q[3];
  assign p2_ref_o     = div_on ? 2'd2 : (wide ? 2'd1 : 2'd0);
  assign p2_fall_o    = div_on;
  assign c8k_oe_o     = div_on;
  assign frame_oe_o   = sel_q[2];
  assign c4_oe_o      = sel_q[3];
  assign var_oe_o     = var_en_i & ~div_on;
  assign var_inv_oe_o = var_en_i;

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(p2_major_o) && $stable(frame_oe_o) && $stable(c4_oe_o)); // R1
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    t1_track_o |-> !tick8k_o && !c8k_oe_o); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last); // R3
  AST_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_div_o && cnt == last) |=> tick8k_o); // R3
  AST_FALL_INT: assert property (@(posedge clk) disable iff (!rst_n)
    p2_fall_o |-> p2_ref_o == 2'd2 && c8k_oe_o); // R5
  AST_VAR_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    t1_div_o |-> !var_oe_o); // R9
endmodule

// File: tb/sim_trunk_mode_div.sv
module sim_trunk_mode_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel = 4'd0;
  logic ven = 1'b0;
  logic t1_track, t1_div, t1_d256, p2_ext, p2_fall, c8k_oe, fr_oe, c4_oe, v_oe, vi_oe, tick;
  logic [1:0] p2_major, p2_ref;
  int vectors = 0, bad = 0;

  always #4 clk = ~clk;

  trunk_mode_div u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(sel), .var_en_i(ven),
    .t1_track_o(t1_track), .t1_div_o(t1_div), .t1_div256_o(t1_d256),
    .p2_major_o(p2_major), .p2_ext4m_o(p2_ext), .p2_ref_o(p2_ref),
    .p2_fall_o(p2_fall), .c8k_oe_o(c8k_oe), .frame_oe_o(fr_oe),
    .c4_oe_o(c4_oe), .var_oe_o(v_oe), .var_inv_oe_o(vi_oe), .tick8k_o(tick));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (sel=%0h ven=%0b)", req, act, exp, sel, ven);
    end
  endtask

  task automatic decode_checks(input logic [3:0] s, input logic e);
    logic a, d;
    a = s[0]; d = s[1];
    chk("R2 track", t1_track, !d);
    chk("R2 divmode", t1_div, d);
    chk("R3 ratio", t1_d256, d & a);
    chk("R4 major", p2_major, {d, a});
    chk("R5 ref", p2_ref, d ? 2 : (a ? 1 : 0));
    chk("R5 edge", p2_fall, d);
    chk("R6 c8k_oe", c8k_oe, d);
    chk("R7 ext4m", p2_ext, !s[3]);
    chk("R7 c4_oe", c4_oe, s[3]);
    chk("R8 frame_oe", fr_oe, s[2]);
    chk("R9 var_oe", v_oe, e & !d);
    chk("R9 var_inv_oe", vi_oe, e);
  endtask

  initial begin
    for (int m = 0; m < 32; m++) begin
      logic [3:0] s;
      logic e;
      int n;
      s = m[3:0]; e = m[4];
      @(negedge clk);
      rst_n = 1'b0; sel = s; ven = e;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      if (m == 0) chk("R2 reset tick", tick, 0);
      decode_checks(s, e);
      sel = ~s;
      n = s[0] ? 256 : 193;
      for (int k = 0; k < 2 * 256 + 3; k++) begin
        if (s[1]) chk("R3 tick", tick, (k % n) < 128);
        else chk("R2 tick idle", tick, 0);
        @(posedge clk); @(negedge clk);
      end
      chk("R1 frozen major", p2_major, s[1:0]);
      decode_checks(s, e);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule